// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency signal by counting its rising edges inside a gate window of known length. The input is brought into the system clock domain through a short flop chain, and each rising edge found there becomes a one-cycle count pulse. A 1 kHz timebase tick, derived elsewhere from the crystal reference, measures out both the gate and a settling wait that comes before it. The count therefore equals the input frequency times the gate time. For example, 342400 edges in a 32 ms gate means 10.7 MHz, and 3600 edges in an 8 ms gate means 450 kHz.

A host controls the block through three signals. A start bit, a two-bit gate select and a latch strobe are taken together at the latch event, which is the moment the serial interface commits new control data. A 0-to-1 change of the start bit arms a measurement. Latching a 0 discards the result. The result and the done flag stay held for as long as the start bit stays 1.

A four-state machine sequences the work. IDLE goes to WAIT when a latch arms a measurement ("arm"). WAIT goes to GATE once the settling ticks have elapsed ("wait over"). GATE goes to DONE on the tick that ends the gate ("gate close"). From any state, a latch that carries a 0 start bit returns the machine to IDLE ("drop"). A second arming latch, given in any state, goes to WAIT.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, count is 0, done is 0 and busy is 0.
- R2: A latch strobe with start_bit=0 moves the block to IDLE by the next clock. From that clock on, count is 0, done is 0 and busy is 0, whatever state the block was in before.
- R3: A latch strobe with start_bit=1, when the start bit last latched was 0, enters WAIT. Busy is 1 from the next clock, and count is cleared.
- R4: A latch strobe with start_bit=1, when the start bit last latched was already 1, has no effect. It does not restart a measurement in progress, does not change the gate length in use, and does not disturb a completed result.
- R5: The wait lasts 4 timebase ticks for gate_sel 2'b00 and 2'b01, and 8 ticks for 2'b10 and 2'b11, counted from the latch. Edges that arrive during the wait are not counted.
- R6: The gate lasts 4, 8, 32 or 64 ticks for gate_sel 2'b00, 2'b01, 2'b10 and 2'b11. Count equals the number of input rising edges seen in the clock cycles after the tick that opens the gate, up to and including the tick that closes it.
- R7: On the clock after the closing tick, done becomes 1 and busy becomes 0. Count and done then hold steady while no latch with start_bit=0 arrives.
- R8: Count saturates at its all-ones value (0xFFFFF for 20 bits) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_ms | input | 1 | One-cycle 1 kHz timebase pulse |
| if_in | input | 1 | IF signal, asynchronous to clk |
| start_bit | input | 1 | Start/reset control bit, used at the latch strobe |
| gate_sel | input | 2 | Gate-length select, used at an arming latch |
| latch_stb | input | 1 | One-cycle latch event (end of a host write) |
| count | output | CNT_W (20) | Edge count, live during the gate and held afterwards |
| done | output | 1 | Measurement complete |
| busy | output | 1 | Waiting or gating |

## Verification
The main function is tried with all four gate selects. The IF period is varied across vectors so that each of them expects a different count. This separates a wrong gate length from a wrong edge rate. Because each IF period divides the gate window exactly, the expected count does not depend on input phase. The bench aligns every latch just after a tick, and then samples done a few cycles before and after the tick that should close the gate. A wait or gate that is off by even one tick is caught that way, and a zero count checked near the end of the wait shows that edges arriving during the wait are not counted. Further directed cases cover a relatch with a different select partway through the gate, an abort during the gate, the hold after completion, and an instance with a narrow count that is driven into saturation.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_GATE = 2'd2,
        ST_DONE = 2'd3
    } ifc_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], async_in};
        end
    end

    // chain_q[SYNC_STAGES-1] is the synchronized level; the top bit is its delayed copy
    assign rise_pulse = chain_q[SYNC_STAGES-1] & ~chain_q[CHAIN-1];

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse)
        else $error("p_pulse_single_r6: edge pulse lasted more than one cycle");

endmodule

// File: rtl/ifc_sat_accum.sv
module ifc_sat_accum #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

    logic [CNT_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clr) begin
            acc_q <= '0;
        end else if (inc && (acc_q != FULL)) begin
            acc_q <= acc_q + 1'b1;
        end
    end

    assign value = acc_q;

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0))
        else $error("p_clear_zero_r2: count not zero after clear");

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (value == FULL) && !clr |=> (value == FULL))
        else $error("p_no_overflow_r8: saturated count moved");

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !clr |=> $stable(value))
        else $error("p_hold_idle_r7: count changed without an edge");

endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
    import ifc_pkg::*;
#(
    parameter int WAIT_SHORT = 4,
    parameter int WAIT_LONG  = 8,
    parameter int GATE_T0    = 4,
    parameter int GATE_T1    = 8,
    parameter int GATE_T2    = 32,
    parameter int GATE_T3    = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       latch_stb,
    input  logic       start_bit,
    input  logic [1:0] gate_sel,
    output logic       acc_clr,
    output logic       gate_open,
    output logic       busy,
    output logic       done
);
    localparam int unsigned MAX_T = max2(max2(max2(GATE_T0, GATE_T1), max2(GATE_T2, GATE_T3)),
                                         max2(WAIT_SHORT, WAIT_LONG));
    localparam int TW = $clog2(MAX_T + 1);

    ifc_state_e      state_q, state_n;
    logic            start_q;
    logic [1:0]      gsel_q;
    logic [TW-1:0]   tcnt_q;
    logic [TW-1:0]   wait_last, gate_last;
    logic            arm, drop;

    assign arm  = latch_stb &  start_bit & ~start_q;
    assign drop = latch_stb & ~start_bit;

    // last tick index of wait and gate for the select taken at arming
    always_comb begin
        unique case (gsel_q)
            2'b00: begin wait_last = TW'(WAIT_SHORT - 1); gate_last = TW'(GATE_T0 - 1); end
            2'b01: begin wait_last = TW'(WAIT_SHORT - 1); gate_last = TW'(GATE_T1 - 1); end
            2'b10: begin wait_last = TW'(WAIT_LONG  - 1); gate_last = TW'(GATE_T2 - 1); end
            default: begin wait_last = TW'(WAIT_LONG - 1); gate_last = TW'(GATE_T3 - 1); end
        endcase
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        if (drop) begin
            state_n = ST_IDLE;
        end else if (arm) begin
            state_n = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_n = ST_IDLE;
                ST_WAIT: if (tick && (tcnt_q == wait_last)) state_n = ST_GATE;
                ST_GATE: if (tick && (tcnt_q == gate_last)) state_n = ST_DONE;
                ST_DONE: state_n = ST_DONE;
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // latched control bits and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            gsel_q  <= 2'b00;
            tcnt_q  <= '0;
        end else begin
            if (latch_stb) start_q <= start_bit;
            if (arm)       gsel_q  <= gate_sel;
            if (drop || arm || (state_n != state_q)) begin
                tcnt_q <= '0;
            end else if (tick && ((state_q == ST_WAIT) || (state_q == ST_GATE))) begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        acc_clr   = drop | arm;
        gate_open = (state_q == ST_GATE);
        busy      = (state_q == ST_WAIT) || (state_q == ST_GATE);
        done      = (state_q == ST_DONE);
    end

    p_drop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (state_q == ST_IDLE))
        else $error("p_drop_idle_r2: latch of 0 did not return to IDLE");

    p_arm_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state_q == ST_WAIT))
        else $error("p_arm_wait_r3: arming latch did not enter WAIT");

    p_relatch_keeps_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb && start_bit && start_q |=> $stable(gsel_q))
        else $error("p_relatch_keeps_sel_r4: gate select changed on relatch");

    p_wait_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> !gate_open)
        else $error("p_wait_no_count_r5: gate open during WAIT");

    p_gate_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GATE) && tick && (tcnt_q == gate_last) && !latch_stb |=> done && !busy)
        else $error("p_gate_close_r7: closing tick did not raise done");

endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
    parameter int CNT_W       = 20,
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_SHORT  = 4,
    parameter int WAIT_LONG   = 8,
    parameter int GATE_T0     = 4,
    parameter int GATE_T1     = 8,
    parameter int GATE_T2     = 32,
    parameter int GATE_T3     = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             if_in,
    input  logic             start_bit,
    input  logic [1:0]       gate_sel,
    input  logic             latch_stb,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             busy
);
    logic if_rise;
    logic acc_clr;
    logic gate_open;

    ifc_edge_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (if_in),
        .rise_pulse (if_rise)
    );

    ifc_ctrl #(
        .WAIT_SHORT (WAIT_SHORT),
        .WAIT_LONG  (WAIT_LONG),
        .GATE_T0    (GATE_T0),
        .GATE_T1    (GATE_T1),
        .GATE_T2    (GATE_T2),
        .GATE_T3    (GATE_T3)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_ms),
        .latch_stb (latch_stb),
        .start_bit (start_bit),
        .gate_sel  (gate_sel),
        .acc_clr   (acc_clr),
        .gate_open (gate_open),
        .busy      (busy),
        .done      (done)
    );

    ifc_sat_accum #(
        .CNT_W (CNT_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .inc   (gate_open & if_rise),
        .value (count)
    );

    p_done_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !latch_stb |=> done && $stable(count))
        else $error("p_done_holds_r7: result not held after completion");

    p_idle_after_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb && !start_bit |=> !busy && !done && (count == '0))
        else $error("p_idle_after_drop_r2: outputs not cleared by latch of 0");

endmodule

// File: tb/test_if_gate_counter.sv
module test_if_gate_counter;

    localparam int TICK_P = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        if_in = 1'b0;
    logic        start_bit = 1'b0;
    logic [1:0]  gate_sel = 2'b00;
    logic        latch_stb = 1'b0;
    logic [19:0] count;
    logic        done, busy;
    logic [7:0]  count_s;
    logic        done_s, busy_s;

    int checks = 0;
    int errors = 0;
    int if_half = 4;

    always #4 clk = ~clk;

    if_gate_counter i_if_gate_counter (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .if_in(if_in),
        .start_bit(start_bit), .gate_sel(gate_sel), .latch_stb(latch_stb),
        .count(count), .done(done), .busy(busy)
    );

    if_gate_counter #(.CNT_W(8)) i_if_gate_counter_sat (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .if_in(if_in),
        .start_bit(start_bit), .gate_sel(gate_sel), .latch_stb(latch_stb),
        .count(count_s), .done(done_s), .busy(busy_s)
    );

    // timebase: one-cycle pulse every TICK_P cycles, driven at negedge
    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            if (div == TICK_P - 1) begin div = 0; tick_ms = 1'b1; end
            else begin div++; tick_ms = 1'b0; end
        end
    end

    // IF source with period 2*if_half cycles
    initial begin
        forever begin
            repeat (if_half) @(negedge clk);
            if_in = ~if_in;
        end
    end

    // {gate_sel, if_half, expected count}
    localparam int VEC[6][3] = '{
        '{0, 4, 20},
        '{1, 5, 32},
        '{2, 10, 64},
        '{3, 2, 640},
        '{0, 20, 4},
        '{1, 2, 80}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_latch(input logic sb, input logic [1:0] sel);
        @(negedge clk);
        latch_stb = 1'b1; start_bit = sb; gate_sel = sel;
        @(negedge clk);
        latch_stb = 1'b0;
    endtask

    // latch start=1 right after a tick; returns at negedge n+2
    task automatic align_latch(input logic [1:0] sel);
        @(negedge clk);
        while (!tick_ms) @(negedge clk);
        do_latch(1'b1, sel);
    endtask

    function automatic int wait_of(input int sel);
        return (sel < 2) ? 4 : 8;
    endfunction

    function automatic int gate_of(input int sel);
        case (sel)
            0: return 4;
            1: return 8;
            2: return 32;
            default: return 64;
        endcase
    endfunction

    task automatic run_meas(input int sel, input int exp);
        int w = wait_of(sel);
        int g = gate_of(sel);
        align_latch(2'(sel));
        chk("R3 busy after arm", int'(busy), 1);
        chk("R3 count cleared at arm", int'(count), 0);
        repeat (TICK_P * w - 5) @(negedge clk);
        chk("R5 no count during wait", int'(count), 0);
        chk("R5 busy during wait", int'(busy), 1);
        repeat (TICK_P * g - 2) @(negedge clk);
        chk("R6 done not before closing tick", int'(done), 0);
        repeat (10) @(negedge clk);
        chk("R7 done after closing tick", int'(done), 1);
        chk("R7 busy low after gate", int'(busy), 0);
        chk("R6 count", int'(count), exp);
        if (sel == 3) chk("R8 saturated count", int'(count_s), 255);
    endtask

    initial begin
        int held;
        repeat (5) @(negedge clk);
        chk("R1 count at reset", int'(count), 0);
        chk("R1 done at reset", int'(done), 0);
        chk("R1 busy at reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 count after reset", int'(count), 0);

        for (int i = 0; i < 6; i++) begin
            do_latch(1'b0, 2'b00);
            chk("R2 count cleared", int'(count), 0);
            chk("R2 done cleared", int'(done), 0);
            chk("R2 busy cleared", int'(busy), 0);
            if_half = VEC[i][1];
            repeat (3 * VEC[i][1] + 4) @(negedge clk);
            run_meas(VEC[i][0], VEC[i][2]);
        end

        // R7: result held while start stays 1
        held = int'(count);
        repeat (100) @(negedge clk);
        chk("R7 count held", int'(count), held);
        chk("R7 done held", int'(done), 1);
        // R4: relatch of 1 after done has no effect
        do_latch(1'b1, 2'b11);
        repeat (TICK_P * 3) @(negedge clk);
        chk("R4 done kept after relatch", int'(done), 1);
        chk("R4 count kept after relatch", int'(count), held);

        // R4: relatch mid-gate with a different select
        do_latch(1'b0, 2'b00);
        if_half = 4;
        repeat (16) @(negedge clk);
        align_latch(2'b00);
        repeat (TICK_P * 6) @(negedge clk);
        do_latch(1'b1, 2'b11);
        repeat (TICK_P * 8 - 2 - TICK_P * 6 - 2 - 5) @(negedge clk);
        chk("R4 relatch does not delay done", int'(done), 0);
        repeat (10) @(negedge clk);
        chk("R4 relatch does not delay done", int'(done), 1);
        chk("R4 relatch keeps count", int'(count), 20);

        // R2: abort during gate
        do_latch(1'b0, 2'b00);
        align_latch(2'b10);
        repeat (TICK_P * 20) @(negedge clk);
        chk("R6 counting in gate", int'(count != 0), 1);
        do_latch(1'b0, 2'b10);
        chk("R2 abort busy", int'(busy), 0);
        chk("R2 abort count", int'(count), 0);
        repeat (TICK_P * 25) @(negedge clk);
        chk("R2 abort no done", int'(done), 0);
        chk("R2 abort count stays 0", int'(count), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule